// File: doc/BRIEF.md
# Control-Port Pin Function Selector

This block holds the per-pin enables for the six upper pins of a control port, numbered 7 down to 2. Each enable decides whether its pin carries an internal bus control signal or serves as general-purpose I/O. Each output pin gets a value and an output enable. Bus functions are the CPU free-cycle flag, the two instruction pipe status bits, the E clock, the low-byte strobe and the read/write line. In general-purpose use, the pin follows the supplied output data and direction bit.

Reset loads defaults that depend on the operating mode. A single lock flag guards four of the enables: the first register write in a normal mode sets it, and the flag is never set in a special mode. The E-clock disable is not guarded and can be rewritten at any time. A register write reaches the pins from the cycle after the clock edge that captures it. Bus signals and general-purpose data pass to the pins combinationally. `mode_i` must be held stable while reset is asserted, because the defaults follow it during reset.

Top module: `busctl_pin_map`

## Requirements
- R1: With `mode_i[0]`=1 (expanded) at reset, pins 4, 3 and 2 carry the E clock, the low strobe and read/write, each driven. Pins 7, 6 and 5 are general-purpose I/O.
- R2: With `mode_i[0]`=0 (single chip) at reset, all six pins are general-purpose I/O.
- R3: In a normal mode (`mode_i[1]`=1), the first write sets a shared lock. Later writes leave `wdata_i` bits 7, 5, 3 and 2 without effect.
- R4: In a special mode (`mode_i[1]`=0), bits 7, 5, 3 and 2 take every write and never lock.
- R5: `wdata_i` bit 4 is taken on every write, even while locked. A 0 puts the E clock on pin 4 and a 1 makes pin 4 general-purpose I/O.
- R6: When bit 7 is 1, pin 7 drives the free-cycle flag.
- R7: When bit 5 is 1, pins 6 and 5 drive `pipe_i[1]` and `pipe_i[0]`.
- R8: When bit 3 is 1, pin 3 drives the low strobe. When bit 2 is 1, pin 2 drives read/write.
- R9: A general-purpose pin outputs its `gpio_dout_i` bit, and its enable equals its `gpio_dir_i` bit (1 = output, 0 = input).
- R10: A write changes the pins from the cycle after the capturing clock edge, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Bit 1: normal (1) or special (0). Bit 0: expanded (1) or single chip (0) |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data; bits 7, 5, 4, 3, 2 used |
| free_cyc_i | input | 1 | CPU free-cycle flag |
| pipe_i | input | 2 | Instruction pipe status |
| eclk_i | input | 1 | E clock |
| lstrb_i | input | 1 | Low-byte strobe |
| rw_i | input | 1 | Read/write |
| gpio_dout_i | input | 6 | General-purpose output data, index 0 = pin 2 |
| gpio_dir_i | input | 6 | General-purpose direction, index 0 = pin 2 |
| pin_o | output | 6 | Pin output values, index 0 = pin 2 |
| pin_oe_o | output | 6 | Pin output enables, index 0 = pin 2 |

## Verification
A wrong enable shows as early as the first mid-cycle sample after reset or after a write. It appears as a pin that follows the wrong source, or whose enable ignores its direction bit. A lock that sets too early or not at all stays hidden until the next write to a guarded field. The bench therefore follows every locking write with a second write that flips all fields, in both normal and special modes. Bus inputs and general-purpose data are toggled between samples so that a wrongly routed pin differs from its expected value.

// File: rtl/busctl_pkg.sv
package busctl_pkg;
  localparam int CTL_PINS = 6;
  localparam int DATA_W   = 8;
  localparam int PIPE_W   = 2;
  // write-data bit positions, aligned to the pin each one controls
  localparam int B_FREE  = 7;
  localparam int B_PIPE  = 5;
  localparam int B_ECLK  = 4;
  localparam int B_LSTRB = 3;
  localparam int B_RW    = 2;
  // pin vector indices (pin number minus 2)
  localparam int I_RW    = 0;
  localparam int I_LSTRB = 1;
  localparam int I_ECLK  = 2;
  localparam int I_PIPE0 = 3;
  localparam int I_PIPE1 = 4;
  localparam int I_FREE  = 5;

  typedef struct packed {
    logic free_en;
    logic pipe_en;
    logic eclk_off;
    logic lstrb_en;
    logic rw_en;
  } pin_cfg_t;

  function automatic pin_cfg_t reset_cfg(input logic expanded);
    pin_cfg_t c;
    c.free_en  = 1'b0;
    c.pipe_en  = 1'b0;
    c.eclk_off = ~expanded;
    c.lstrb_en = expanded;
    c.rw_en    = expanded;
    return c;
  endfunction
endpackage

// File: rtl/busctl_once_lock.sv
module busctl_once_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic normal_i,
  output logic locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) locked_o <= 1'b0;
    else if (wr_i && normal_i) locked_o <= 1'b1;
  end

  p_lock_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(wr_i && normal_i));
  p_lock_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
  p_no_lock_special_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_o && !normal_i) |=> !locked_o);
endmodule

// File: rtl/busctl_cfg_reg.sv
module busctl_cfg_reg
  import busctl_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          expanded_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          locked_i,
  output pin_cfg_t      cfg_o
);
  pin_cfg_t cfg_q;

  // defaults track the strapped mode while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= reset_cfg(expanded_i);
    end else if (wr_i) begin
      cfg_q.eclk_off <= wdata_i[B_ECLK];
      if (!locked_i) begin
        cfg_q.free_en  <= wdata_i[B_FREE];
        cfg_q.pipe_en  <= wdata_i[B_PIPE];
        cfg_q.lstrb_en <= wdata_i[B_LSTRB];
        cfg_q.rw_en    <= wdata_i[B_RW];
      end
    end
  end

  assign cfg_o = cfg_q;

  p_once_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> $stable({cfg_q.free_en, cfg_q.pipe_en, cfg_q.lstrb_en, cfg_q.rw_en}));
  p_eclk_any_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cfg_q.eclk_off == $past(wdata_i[B_ECLK]));
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cfg_q));
endmodule

// File: rtl/busctl_pin_mux.sv
module busctl_pin_mux
  import busctl_pkg::*;
#(
  parameter int NP = CTL_PINS,
  parameter int PW = PIPE_W
) (
  input  pin_cfg_t        cfg_i,
  input  logic            free_cyc_i,
  input  logic [PW-1:0]   pipe_i,
  input  logic            eclk_i,
  input  logic            lstrb_i,
  input  logic            rw_i,
  input  logic [NP-1:0]   gpio_dout_i,
  input  logic [NP-1:0]   gpio_dir_i,
  output logic [NP-1:0]   pin_o,
  output logic [NP-1:0]   pin_oe_o
);
  logic [NP-1:0] bus_en, bus_val;

  always_comb begin
    bus_en  = '0;
    bus_val = '0;
    bus_en[I_RW]     = cfg_i.rw_en;
    bus_val[I_RW]    = rw_i;
    bus_en[I_LSTRB]  = cfg_i.lstrb_en;
    bus_val[I_LSTRB] = lstrb_i;
    bus_en[I_ECLK]   = ~cfg_i.eclk_off;
    bus_val[I_ECLK]  = eclk_i;
    bus_en[I_PIPE0]  = cfg_i.pipe_en;
    bus_val[I_PIPE0] = pipe_i[0];
    bus_en[I_PIPE1]  = cfg_i.pipe_en;
    bus_val[I_PIPE1] = pipe_i[PW-1];
    bus_en[I_FREE]   = cfg_i.free_en;
    bus_val[I_FREE]  = free_cyc_i;
  end

  for (genvar i = 0; i < NP; i++) begin : g_pin
    assign pin_o[i]    = bus_en[i] ? bus_val[i] : gpio_dout_i[i];
    assign pin_oe_o[i] = bus_en[i] | gpio_dir_i[i];
  end
endmodule

// File: rtl/busctl_pin_map.sv
module busctl_pin_map
  import busctl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                free_cyc_i,
  input  logic [PIPE_W-1:0]   pipe_i,
  input  logic                eclk_i,
  input  logic                lstrb_i,
  input  logic                rw_i,
  input  logic [CTL_PINS-1:0] gpio_dout_i,
  input  logic [CTL_PINS-1:0] gpio_dir_i,
  output logic [CTL_PINS-1:0] pin_o,
  output logic [CTL_PINS-1:0] pin_oe_o
);
  logic     locked;
  pin_cfg_t cfg;

  busctl_once_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .normal_i (mode_i[1]),
    .locked_o (locked)
  );

  busctl_cfg_reg #(.DW(DATA_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .expanded_i (mode_i[0]),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .locked_i   (locked),
    .cfg_o      (cfg)
  );

  busctl_pin_mux #(.NP(CTL_PINS), .PW(PIPE_W)) u_mux (
    .cfg_i       (cfg),
    .free_cyc_i  (free_cyc_i),
    .pipe_i      (pipe_i),
    .eclk_i      (eclk_i),
    .lstrb_i     (lstrb_i),
    .rw_i        (rw_i),
    .gpio_dout_i (gpio_dout_i),
    .gpio_dir_i  (gpio_dir_i),
    .pin_o       (pin_o),
    .pin_oe_o    (pin_oe_o)
  );

  p_rw_pin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.rw_en |-> (pin_oe_o[I_RW] && pin_o[I_RW] == rw_i));
  p_free_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.free_en |-> (pin_oe_o[I_FREE] && pin_o[I_FREE] == free_cyc_i));
  p_eclk_pin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.eclk_off |-> (pin_oe_o[I_ECLK] && pin_o[I_ECLK] == eclk_i));
  p_gpio_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.free_en |-> (pin_oe_o[I_FREE] == gpio_dir_i[I_FREE]
                      && pin_o[I_FREE] == gpio_dout_i[I_FREE]));
endmodule

// File: tb/sim_busctl_pin_map.sv
module sim_busctl_pin_map;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b11;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       free_cyc = 1'b0, eclk = 1'b0, lstrb = 1'b0, rw = 1'b0;
  logic [1:0] pipe = '0;
  logic [5:0] dout = '0, dir = '0;
  logic [5:0] pin, oe;

  typedef struct {
    logic [5:0] pin;
    logic [5:0] oe;
    string      tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the register
  logic m_free, m_pipe, m_eoff, m_lstrb, m_rw, m_lock;

  always #10 clk = ~clk;

  busctl_pin_map u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .wr_i(wr), .wdata_i(wdata),
    .free_cyc_i(free_cyc), .pipe_i(pipe), .eclk_i(eclk), .lstrb_i(lstrb),
    .rw_i(rw), .gpio_dout_i(dout), .gpio_dir_i(dir), .pin_o(pin), .pin_oe_o(oe)
  );

  function automatic void push_exp(string tag);
    exp_t e;
    logic [5:0] en, val;
    en  = {m_free, m_pipe, m_pipe, ~m_eoff, m_lstrb, m_rw};
    val = {free_cyc, pipe[1], pipe[0], eclk, lstrb, rw};
    e.pin = (en & val) | (~en & dout);
    e.oe  = en | dir;
    e.tag = tag;
    q.push_back(e);
  endfunction

  // monitor: compare mid-cycle
  initial forever begin
    @(negedge clk);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pin !== e.pin || oe !== e.oe) begin
        errors++;
        $display("FAIL %s pin=%b oe=%b expected pin=%b oe=%b", e.tag, pin, oe, e.pin, e.oe);
      end
    end
  end

  task automatic do_reset(input logic [1:0] md, string tag);
    @(posedge clk); #1;
    mode = md; wr = 1'b0; rst_n = 1'b0;
    m_free = 0; m_pipe = 0; m_eoff = ~md[0]; m_lstrb = md[0]; m_rw = md[0]; m_lock = 0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    push_exp(tag);
    @(negedge clk);
  endtask

  // one cycle: drive, optionally write, check after the edge
  task automatic step(input logic w, input logic [7:0] d, input logic [5:0] bus,
                      input logic [5:0] go, input logic [5:0] gd, string tag);
    @(posedge clk); #1;
    wr = w; wdata = d;
    {free_cyc, pipe, eclk, lstrb, rw} = bus;
    dout = go; dir = gd;
    if (w) begin
      m_eoff = d[4];
      if (!m_lock) begin
        m_free = d[7]; m_pipe = d[5]; m_lstrb = d[3]; m_rw = d[2];
      end
      if (mode[1]) m_lock = 1;
    end
    @(posedge clk); #1;
    wr = 1'b0;
    push_exp(tag);
    @(negedge clk);
  endtask

  // pre-edge check for R10: state must still be old before capture edge
  task automatic early_check(input logic [7:0] d, string tag);
    @(posedge clk); #1;
    wr = 1'b1; wdata = d;
    push_exp(tag);
    @(negedge clk);
    @(posedge clk); #1;
    wr = 1'b0;
    m_eoff = d[4];
    if (!m_lock) begin
      m_free = d[7]; m_pipe = d[5]; m_lstrb = d[3]; m_rw = d[2];
    end
    if (mode[1]) m_lock = 1;
    push_exp(tag);
    @(negedge clk);
  endtask

  initial begin
    // R1 normal expanded defaults
    do_reset(2'b11, "R1");
    step(0, 8'h00, 6'b000111, 6'b101010, 6'b110000, "R1");
    step(0, 8'h00, 6'b111000, 6'b010101, 6'b001111, "R1");
    step(0, 8'h00, 6'b000101, 6'b000000, 6'b000000, "R8");
    step(0, 8'h00, 6'b000010, 6'b111111, 6'b111111, "R8");
    // first write locks; enables free and pipe, drops strobe and rw
    step(1, 8'b1010_0000, 6'b101010, 6'b010101, 6'b111111, "R6");
    step(0, 8'h00, 6'b010101, 6'b101010, 6'b000000, "R7");
    step(0, 8'h00, 6'b100000, 6'b000000, 6'b000000, "R6");
    // locked: only bit 4 lands
    step(1, 8'b0101_1100, 6'b111111, 6'b000000, 6'b000000, "R3");
    step(0, 8'h00, 6'b000000, 6'b111111, 6'b101010, "R5");
    step(1, 8'h00, 6'b111111, 6'b000000, 6'b010101, "R5");
    step(1, 8'hff, 6'b000000, 6'b110011, 6'b000000, "R3");
    // R2 single-chip defaults
    do_reset(2'b10, "R2");
    step(0, 8'h00, 6'b111111, 6'b100101, 6'b011010, "R9");
    step(0, 8'h00, 6'b111111, 6'b011010, 6'b100101, "R9");
    early_check(8'b0000_1100, "R10");
    step(1, 8'b1010_0000, 6'b111111, 6'b000000, 6'b000000, "R3");
    // R4 special expanded: never locks
    do_reset(2'b01, "R1");
    step(1, 8'b0000_0000, 6'b111111, 6'b000000, 6'b000000, "R4");
    step(1, 8'b1010_0000, 6'b101010, 6'b000000, 6'b000000, "R4");
    step(1, 8'b0001_1100, 6'b010101, 6'b111111, 6'b000000, "R4");
    step(1, 8'b1010_1100, 6'b111111, 6'b000000, 6'b000000, "R4");
    // special single chip
    do_reset(2'b00, "R2");
    early_check(8'b1000_0100, "R10");
    step(1, 8'b0010_1000, 6'b111111, 6'b000000, 6'b000000, "R4");
    done = 1;
    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule